// File: doc/BRIEF.md
# DMA Master Backend Handshake Controller

This block sequences one master-mode DMA transfer at a time between a bus interface core and user backend logic. It runs entirely in one bus-clock domain. A request from the control register carries a direction, a 3-bit target-region code and a word count. The controller waits until the backend can take part in the chosen direction. It then frames the transfer with an active flag and single-cycle start and done pulses, and asks the bus side to open a burst. While the burst runs, it drives the backend read or write strobes.

The backend controls the transfer through four inputs. A stall input, sampled in the start cycle, holds off the burst request until the backend is ready. A stop input ends the transfer early. After a stop, the controller performs the post-stop backend transfer that the direction calls for. The region output lets the backend select which FIFO's empty or full flag is routed onto the busy inputs.

Top module: `dma_mst_ctrl`

## Requirements
- R1: While rst_ni is low, every output is low and the controller is idle.
- R2: A request with a nonzero count is accepted only while idle. busy_o is high from the next cycle until the cycle after done_o. A request with a zero count is ignored, and so is a request made while busy_o is high.
- R3: region_o shows the 3-bit region captured when a request is accepted. It holds that value until the next accepted request.
- R4: After acceptance, a read-from-backend transfer (dir_i=1) waits while rd_busy_i is high, and a write-to-backend transfer (dir_i=0) waits while wr_busy_i is high. The busy input for the other direction has no effect. active_o rises the cycle after the selected busy input is seen low.
- R5: active_o rises one cycle before start_o and falls one cycle before done_o. start_o and done_o are each a single-cycle pulse, issued once per transfer.
- R6: stall_i is sampled in the start_o cycle. If it is low, frame_req_o rises in the next cycle. If it is high, frame_req_o stays low until the cycle after stall_i is seen low.
- R7: frame_req_o is high for the whole bus data phase. Each cycle in that phase with bus_ack_i high moves one word. After the word that matches the count, frame_req_o and active_o fall in the next cycle.
- R8: stop_i takes effect in the data phase only after at least one word has moved. If stop_i is high from the start, exactly one word moves. In a data-phase cycle where stop_i takes effect, bus_ack_i is ignored and frame_req_o falls in the next cycle.
- R9: For writes to the backend, wr_strobe_o pulses in every cycle that moves a word. After a stop takes effect, exactly one more wr_strobe_o follows in the next cycle.
- R10: For reads from the backend, rd_strobe_o is high in every data-phase cycle. After a stop, it stays high for one extra cycle only if, in the cycle before the stop, rd_strobe_o was high and rd_valid_i was low.
- R11: With MASTER_EN set to 0, requests are never accepted and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_req_i | input | 1 | Request pulse from the control register |
| dma_dir_i | input | 1 | 1 = read from backend, 0 = write to backend |
| dma_region_i | input | REG_W | Target region code |
| xfer_count_i | input | CNT_W | Number of words to move |
| rd_busy_i | input | 1 | Backend cannot supply data |
| wr_busy_i | input | 1 | Backend cannot accept data |
| stop_i | input | 1 | Backend stop request |
| stall_i | input | 1 | Backend not yet ready at start |
| bus_ack_i | input | 1 | Bus side moved one word this cycle |
| rd_valid_i | input | 1 | Backend returned read data this cycle |
| active_o | output | 1 | Master transfer in progress |
| busy_o | output | 1 | DMA request being processed |
| start_o | output | 1 | Start pulse |
| done_o | output | 1 | Done pulse |
| region_o | output | REG_W | Captured region code |
| frame_req_o | output | 1 | Request to hold the bus burst open |
| rd_strobe_o | output | 1 | Backend read strobe |
| wr_strobe_o | output | 1 | Backend write strobe |

## Verification
Write transfers run with a continuous acknowledge, with the write-busy input held, and with stall held, so that the waiting point can be seen separately from the frame hold-off. A read transfer runs with the acknowledge toggled every other cycle, and another runs with only the opposite busy input asserted; together they show that only acked cycles are counted and that the busy gating follows the direction. Stop is tried in three patterns: held from the start of a write, raised mid-read with read data withheld, and raised mid-read with data returned. These separate the one-word minimum from the conditional extra read strobe. Zero-count requests, overlapping requests and a disabled instance confirm what is ignored.

// File: rtl/dma_mst_pkg.sv
package dma_mst_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_START,
    ST_STALL,
    ST_XFER,
    ST_DRAIN,
    ST_END,
    ST_DONE
  } dma_st_e;
endpackage

// File: rtl/dma_mst_cnt.sv
module dma_mst_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             moved_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             moved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      moved_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      moved_q <= 1'b0;
    end else if (dec_i) begin
      cnt_q   <= cnt_q - ONE;
      moved_q <= 1'b1;
    end
  end

  assign last_o  = (cnt_q == ONE);
  assign moved_o = moved_q;
endmodule

// File: rtl/dma_mst_strb.sv
module dma_mst_strb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic xfer_i,
  input  logic drain_i,
  input  logic ack_eff_i,
  input  logic rd_valid_i,
  output logic rd_strobe_o,
  output logic wr_strobe_o,
  output logic owed_o
);
  logic owed_q;

  assign rd_strobe_o = dir_i & (xfer_i | drain_i);
  assign wr_strobe_o = ~dir_i & (ack_eff_i | drain_i);

  // read request issued but not yet answered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= 1'b0;
    else         owed_q <= rd_strobe_o & ~rd_valid_i;
  end

  assign owed_o = owed_q;
endmodule

// File: rtl/dma_mst_fsm.sv
module dma_mst_fsm
  import dma_mst_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cnt_nz_i,
  input  logic             dir_i,
  input  logic [REG_W-1:0] region_i,
  input  logic             rd_busy_i,
  input  logic             wr_busy_i,
  input  logic             stall_i,
  input  logic             stop_i,
  input  logic             ack_i,
  input  logic             last_i,
  input  logic             moved_i,
  input  logic             owed_i,
  output dma_st_e          state_o,
  output logic             dir_q_o,
  output logic [REG_W-1:0] region_q_o,
  output logic             accept_o,
  output logic             ack_eff_o
);
  dma_st_e          st_q, st_d;
  logic             dir_q;
  logic [REG_W-1:0] region_q;
  logic             in_xfer, stop_eff, sel_busy;

  assign accept_o  = (st_q == ST_IDLE) & req_i & cnt_nz_i;
  assign in_xfer   = (st_q == ST_XFER);
  assign stop_eff  = in_xfer & stop_i & moved_i;
  assign ack_eff_o = in_xfer & ack_i & ~stop_eff;
  assign sel_busy  = dir_q ? rd_busy_i : wr_busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_o) st_d = ST_WAIT;
      ST_WAIT:  if (!sel_busy) st_d = ST_PRE;
      ST_PRE:   st_d = ST_START;
      ST_START: st_d = stall_i ? ST_STALL : ST_XFER;
      ST_STALL: if (!stall_i) st_d = ST_XFER;
      ST_XFER: begin
        if (stop_eff)                st_d = (!dir_q || owed_i) ? ST_DRAIN : ST_END;
        else if (ack_eff_o && last_i) st_d = ST_END;
      end
      ST_DRAIN: st_d = ST_END;
      ST_END:   st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      dir_q    <= 1'b0;
      region_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        dir_q    <= dir_i;
        region_q <= region_i;
      end
    end
  end

  assign state_o    = st_q;
  assign dir_q_o    = dir_q;
  assign region_q_o = region_q;
endmodule

// File: rtl/dma_mst_ctrl.sv
module dma_mst_ctrl
  import dma_mst_pkg::*;
#(
  parameter int MASTER_EN = 1,
  parameter int CNT_W     = 8,
  parameter int REG_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_req_i,
  input  logic             dma_dir_i,
  input  logic [REG_W-1:0] dma_region_i,
  input  logic [CNT_W-1:0] xfer_count_i,
  input  logic             rd_busy_i,
  input  logic             wr_busy_i,
  input  logic             stop_i,
  input  logic             stall_i,
  input  logic             bus_ack_i,
  input  logic             rd_valid_i,
  output logic             active_o,
  output logic             busy_o,
  output logic             start_o,
  output logic             done_o,
  output logic [REG_W-1:0] region_o,
  output logic             frame_req_o,
  output logic             rd_strobe_o,
  output logic             wr_strobe_o
);
  localparam logic EN = (MASTER_EN != 0);

  dma_st_e st;
  logic    dir_q, accept, ack_eff, last, moved, owed, req_g;

  assign req_g = dma_req_i & EN;

  dma_mst_fsm #(.REG_W(REG_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_g),
    .cnt_nz_i   (|xfer_count_i),
    .dir_i      (dma_dir_i),
    .region_i   (dma_region_i),
    .rd_busy_i  (rd_busy_i),
    .wr_busy_i  (wr_busy_i),
    .stall_i    (stall_i),
    .stop_i     (stop_i),
    .ack_i      (bus_ack_i),
    .last_i     (last),
    .moved_i    (moved),
    .owed_i     (owed),
    .state_o    (st),
    .dir_q_o    (dir_q),
    .region_q_o (region_o),
    .accept_o   (accept),
    .ack_eff_o  (ack_eff)
  );

  dma_mst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (xfer_count_i),
    .dec_i      (ack_eff),
    .last_o     (last),
    .moved_o    (moved)
  );

  dma_mst_strb u_strb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (dir_q),
    .xfer_i      (st == ST_XFER),
    .drain_i     (st == ST_DRAIN),
    .ack_eff_i   (ack_eff),
    .rd_valid_i  (rd_valid_i),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .owed_o      (owed)
  );

  assign active_o    = (st == ST_PRE) | (st == ST_START) | (st == ST_STALL) |
                       (st == ST_XFER) | (st == ST_DRAIN);
  assign busy_o      = (st != ST_IDLE);
  assign start_o     = (st == ST_START);
  assign done_o      = (st == ST_DONE);
  assign frame_req_o = (st == ST_XFER);
endmodule

// File: rtl/dma_mst_ctrl_chk.sv
module dma_mst_ctrl_chk #(
  parameter int REG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_o,
  input logic             busy_o,
  input logic             start_o,
  input logic             done_o,
  input logic [REG_W-1:0] region_o,
  input logic             frame_req_o,
  input logic             rd_strobe_o,
  input logic             wr_strobe_o,
  input logic             stall_i
);
  a_r5_start_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_o && $past(active_o));
  a_r5_done_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o && !$past(active_o) && $past(active_o, 2));
  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  a_r3_region_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(region_o));
  a_r7_frame_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_req_o |-> active_o && busy_o);
  a_r6_frame_after_unstall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_req_o) |-> !$past(stall_i));
  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_o && wr_strobe_o));
endmodule

bind dma_mst_ctrl dma_mst_ctrl_chk #(.REG_W(REG_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_o    (active_o),
  .busy_o      (busy_o),
  .start_o     (start_o),
  .done_o      (done_o),
  .region_o    (region_o),
  .frame_req_o (frame_req_o),
  .rd_strobe_o (rd_strobe_o),
  .wr_strobe_o (wr_strobe_o),
  .stall_i     (stall_i)
);

// File: tb/dma_mst_ctrl_tb.sv
module dma_mst_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 0, dir = 0, rd_busy = 0, wr_busy = 0, stop = 0, stall = 0;
  logic       ack = 1, rd_valid = 1;
  logic [2:0] region = 0;
  logic [7:0] count = 0;

  logic       act, bsy, stt, dne, frm, rds, wrs;
  logic [2:0] reg_o;
  logic       x_act, x_bsy, x_stt, x_dne, x_frm, x_rds, x_wrs;
  logic [2:0] x_reg;

  int checks = 0, fails = 0, cyc = 0, wcnt = 0;
  bit finished = 0;

  // model state: 0 idle 1 wait 2 lead 3 start 4 stall 5 data 6 extra 7 tail 8 done
  int   m_ph = 0, m_left = 0;
  bit   m_dir = 0, m_moved = 0, m_owed = 0;
  logic [2:0] m_reg = 0;

  always #2.5 clk = ~clk;

  dma_mst_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dma_req_i(req), .dma_dir_i(dir),
    .dma_region_i(region), .xfer_count_i(count), .rd_busy_i(rd_busy),
    .wr_busy_i(wr_busy), .stop_i(stop), .stall_i(stall), .bus_ack_i(ack),
    .rd_valid_i(rd_valid), .active_o(act), .busy_o(bsy), .start_o(stt),
    .done_o(dne), .region_o(reg_o), .frame_req_o(frm), .rd_strobe_o(rds),
    .wr_strobe_o(wrs));

  dma_mst_ctrl #(.MASTER_EN(0)) dut_off (
    .clk_i(clk), .rst_ni(rst_n), .dma_req_i(req), .dma_dir_i(dir),
    .dma_region_i(region), .xfer_count_i(count), .rd_busy_i(rd_busy),
    .wr_busy_i(wr_busy), .stop_i(stop), .stall_i(stall), .bus_ack_i(ack),
    .rd_valid_i(rd_valid), .active_o(x_act), .busy_o(x_bsy), .start_o(x_stt),
    .done_o(x_dne), .region_o(x_reg), .frame_req_o(x_frm), .rd_strobe_o(x_rds),
    .wr_strobe_o(x_wrs));

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  function automatic bit e_stop();
    return m_ph == 5 && stop && m_moved;
  endfunction
  function automatic bit e_ack();
    return m_ph == 5 && ack && !e_stop();
  endfunction
  function automatic bit e_rd();
    return m_dir && (m_ph == 5 || m_ph == 6);
  endfunction

  task automatic compare();
    chk({7'd0, act}, {7'd0, m_ph >= 2 && m_ph <= 6}, "R5 active");
    chk({7'd0, stt}, {7'd0, m_ph == 3}, "R5 start");
    chk({7'd0, dne}, {7'd0, m_ph == 8}, "R5 done");
    chk({7'd0, bsy}, {7'd0, m_ph != 0}, "R2 busy");
    chk({5'd0, reg_o}, {5'd0, m_reg}, "R3 region");
    chk({7'd0, frm}, {7'd0, m_ph == 5}, "R7 frame");
    chk({7'd0, wrs}, {7'd0, !m_dir && (e_ack() || m_ph == 6)}, "R9 wr_strobe");
    chk({7'd0, rds}, {7'd0, e_rd()}, "R10 rd_strobe");
    chk({x_act, x_bsy, x_stt, x_dne, x_frm, x_rds, x_wrs, 1'b0} | {5'd0, x_reg}, 8'd0,
        "R11 disabled");
  endtask

  task automatic model_step();
    bit sb, ow, ea, es;
    sb = m_dir ? rd_busy : wr_busy;
    ea = e_ack();
    es = e_stop();
    ow = e_rd() && !rd_valid;
    case (m_ph)
      0: if (req && count != 0) begin
           m_ph = 1; m_dir = dir; m_reg = region; m_left = count; m_moved = 0;
         end
      1: if (!sb) m_ph = 2;
      2: m_ph = 3;
      3: m_ph = stall ? 4 : 5;
      4: if (!stall) m_ph = 5;
      5: begin
           if (es) m_ph = (!m_dir || m_owed) ? 6 : 7;
           else if (ea) begin
             m_moved = 1;
             if (m_left == 1) m_ph = 7;
             m_left--;
           end
         end
      6: m_ph = 7;
      7: m_ph = 8;
      default: m_ph = 0;
    endcase
    m_owed = ow;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
      if (wrs) wcnt++;
      @(posedge clk);
      model_step();
      cyc++;
      #1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk({act, bsy, stt, dne, frm, rds, wrs, 1'b0} | {5'd0, reg_o}, 8'd0, "R1 reset");
    end
    @(posedge clk); #1 rst_n = 1;

    // write, count 3, overlapping request ignored
    req = 1; dir = 0; region = 5; count = 3; step(1);
    req = 0; step(3);
    req = 1; region = 2; step(1);
    req = 0; step(10);
    chk({5'd0, reg_o}, 8'd5, "R3 region kept");

    // zero count ignored
    req = 1; count = 0; region = 6; step(1);
    req = 0; step(3);
    chk({7'd0, bsy}, 8'd0, "R2 zero count");

    // write waits on wr_busy
    wr_busy = 1; req = 1; dir = 0; count = 2; region = 1; step(1);
    req = 0; step(3);
    chk({7'd0, act}, 8'd0, "R4 write held");
    wr_busy = 0; step(10);

    // read not blocked by wr_busy
    wr_busy = 1; req = 1; dir = 1; count = 2; region = 3; step(1);
    req = 0; step(2);
    chk({7'd0, act}, 8'd1, "R4 read runs");
    wr_busy = 0; step(10);

    // stall holds frame
    stall = 1; req = 1; dir = 0; count = 2; region = 4; step(1);
    req = 0; step(6);
    chk({7'd0, frm}, 8'd0, "R6 stalled");
    stall = 0; step(10);

    // read with ack gaps
    req = 1; dir = 1; count = 3; region = 7; step(1);
    req = 0;
    for (int i = 0; i < 20; i++) begin ack = i[0]; step(1); end
    ack = 1;

    // stop from start, write: one word plus one extra strobe
    stop = 1; wcnt = 0; req = 1; dir = 0; count = 5; region = 2; step(1);
    req = 0; step(12);
    chk(8'(wcnt), 8'd2, "R8 stop at start");
    chk({7'd0, bsy}, 8'd0, "R8 ended");
    stop = 0;

    // read stop with request outstanding
    rd_valid = 0; req = 1; dir = 1; count = 8; step(1);
    req = 0; step(6); stop = 1; step(6); stop = 0; step(4);

    // read stop with data returned
    rd_valid = 1; req = 1; dir = 1; count = 8; step(1);
    req = 0; step(6); stop = 1; step(6); stop = 0; step(4);

    finish_run();
  end
endmodule